// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block produces the word addresses a display engine reads to fill its visible window from a framebuffer. It keeps two start addresses, one for each field. It also takes one packed size word that gives the row width, the row count and the row-to-row modulo. At every field start it captures that setup and picks its start address. Each line-start pulse from the timing generator then opens one row. The block walks the row one 32-bit word at a time and advances by the modulo when moving to the next row.

In progressive scanning the modulo is 1, so rows sit back to back. For interlaced scanning, software sets the short-field start one line length past the long-field start. The modulo becomes 1 plus the line length in words, and the row count becomes half the vertical resolution, so each field reads every other line. The line length in words is the pixel count times the bits per pixel, rounded up to a multiple of 32 bits and then divided by 32. Reads leave on a request/acknowledge port. The address stays where it is for as long as the consumer withholds the acknowledge.

Top module: `dwin_fetch_addr`

## Requirements
- R1: After reset no read is requested and `field_short` is 0. A line start seen before the first field start opens no row.
- R2: `size_cfg` is decoded as width-in-words minus one in bits 9:0, rows minus one in bits 19:10, and the modulo in bits 29:20.
- R3: Within a row, each acknowledged word is followed by the next consecutive word address. A row holds exactly width-field plus one words.
- R4: The first word of the next row is the last word of the previous row plus the modulo. Row r of a field therefore starts at base + r × (width field + modulo), and a modulo of 1 gives contiguous rows.
- R5: A row starts only on a line start that arrives while the block waits for a row. A line start during an active row has no effect. Once rows-field plus one rows are done, no request appears until the next field start.
- R6: With `interlace_en` at 1, field starts alternate between the long-field start and the short-field start, beginning with the long one after reset or after any progressive field. With `interlace_en` at 0 the long-field start is always used. `field_short` is 1 during a field that started from the short-field address.
- R7: While `rd_req` is 1 and `rd_ack` is 0, the request and its address hold unchanged into the next cycle, and no word is skipped.
- R8: The start addresses, `size_cfg` and `interlace_en` are sampled only in a field-start cycle. Changing them during a field leaves that field's addresses unchanged.
- R9: A field start always ends any row in progress: `rd_req` is 0 in the following cycle and the next field uses the newly sampled setup.
- R10: An interlaced pair of fields, set up with the line length computed as in the description, reads every word of the frame exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| line_start | input | 1 | One-cycle pulse that opens the next row |
| interlace_en | input | 1 | 1 = alternate long and short fields |
| long_base | input | ADDR_W | Long-field start word address |
| short_base | input | ADDR_W | Short-field start word address |
| size_cfg | input | 3*CNT_W | Packed modulo, rows minus one, width minus one |
| rd_ack | input | 1 | Consumer accepts the current address |
| rd_req | output | 1 | A read address is offered |
| rd_addr | output | ADDR_W | Word address of the offered read |
| field_short | output | 1 | Current field started from the short-field address |

## Verification
On every cycle, assertions check the following: the request and address hold while the consumer stalls, each accepted word inside a row is followed by the next word, a row jump adds the captured modulo, a request never appears without a line start, a field start kills the request, and a progressive field never reports the short field. Only the bench scenarios can show the things no single cycle reveals. These are the full address sequence across a sweep of widths, row counts, moduli and both scan modes, the long/short alternation over many fields, immunity to setup changes made mid-field, and an interlaced pair that reads the whole frame exactly once.

// File: rtl/dwin_pkg.sv
// Shared types for the display window fetch address generator.
// Assumes nothing beyond the parameters passed by the users of the package.
package dwin_pkg;

    // Scan sequencer states
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,   // no field started since reset
        SC_WAIT = 2'd1,   // waiting for a line start to open a row
        SC_ROW  = 2'd2,   // issuing words of a row
        SC_DONE = 2'd3    // all rows of the field are issued
    } scan_state_t;

    // Number of fields packed in the size word
    localparam int SIZE_FIELDS = 3;

endpackage

// File: rtl/dwin_cfg_latch.sv
// Field setup capture.
// Unpacks the size word (width-1, rows-1, modulo from low to high) and
// captures it at each field start. It also tracks the long/short field
// alternation of interlaced scanning. Assumes field_start is a one-cycle pulse.
module dwin_cfg_latch
    import dwin_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         field_start,
    input  logic                         interlace_en,
    input  logic [ADDR_W-1:0]            long_base,
    input  logic [ADDR_W-1:0]            short_base,
    input  logic [SIZE_FIELDS*CNT_W-1:0] size_word,
    output logic [CNT_W-1:0]             width_m1,
    output logic [CNT_W-1:0]             rows_m1,
    output logic [CNT_W-1:0]             modulo,
    output logic [ADDR_W-1:0]            start_base,
    output logic                         field_short
);

    logic [CNT_W-1:0] fld [SIZE_FIELDS];
    logic             next_short;

    // Slice the packed size word into its equal-width fields
    for (genvar g = 0; g < SIZE_FIELDS; g++) begin : g_unpack
        assign fld[g] = size_word[g*CNT_W +: CNT_W];
    end

    // Start address the field about to begin will use
    always_comb start_base = (interlace_en && next_short) ? short_base : long_base;

    // Capture the setup and advance the field parity at field start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_m1    <= '0;
            rows_m1     <= '0;
            modulo      <= '0;
            field_short <= 1'b0;
            next_short  <= 1'b0;
        end else if (field_start) begin
            width_m1    <= fld[0];
            rows_m1     <= fld[1];
            modulo      <= fld[2];
            field_short <= interlace_en && next_short;
            next_short  <= interlace_en && !next_short;
        end
    end

    // R6: a progressive field never reports the short field
    assert_prog_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && !interlace_en |=> !field_short);

    // R6: in interlaced mode a short field is followed by a long one
    assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && interlace_en && field_short |=> !field_short);

endmodule

// File: rtl/dwin_scan_ctrl.sv
// Row and word sequencer.
// Opens a row on line start, counts accepted words up to the width field,
// and counts rows up to the row field. A field start restarts the sequence
// from any state. Assumes the width and row limits are stable during a field.
module dwin_scan_ctrl
    import dwin_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_start,
    input  logic             rd_ack,
    input  logic [CNT_W-1:0] width_m1,
    input  logic [CNT_W-1:0] rows_m1,
    output logic             rd_req,
    output logic             word_adv,
    output logic             row_adv
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    scan_state_t      state;
    logic [CNT_W-1:0] word_cnt;
    logic [CNT_W-1:0] row_cnt;
    logic             word_last;
    logic             beat;

    // Decode request and the kind of step an accepted word causes
    always_comb begin
        word_last = (word_cnt == width_m1);
        rd_req    = (state == SC_ROW);
        beat      = rd_req && rd_ack;
        word_adv  = beat && !word_last;
        row_adv   = beat && word_last;
    end

    // Sequence rows and words; field start has priority over everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SC_IDLE;
            word_cnt <= '0;
            row_cnt  <= '0;
        end else if (field_start) begin
            state    <= SC_WAIT;
            word_cnt <= '0;
            row_cnt  <= '0;
        end else begin
            case (state)
                SC_WAIT: begin
                    if (line_start) begin
                        state    <= SC_ROW;
                        word_cnt <= '0;
                    end
                end
                SC_ROW: begin
                    if (word_adv) begin
                        word_cnt <= word_cnt + CNT_ONE;
                    end else if (row_adv) begin
                        word_cnt <= '0;
                        if (row_cnt == rows_m1) begin
                            state <= SC_DONE;
                        end else begin
                            row_cnt <= row_cnt + CNT_ONE;
                            state   <= SC_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: a request only appears after a line start
    assert_no_unopened_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req && !line_start |=> !rd_req);

    // R9: a field start ends any row in progress
    assert_field_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !rd_req);

endmodule

// File: rtl/dwin_addr_step.sv
// Word address register.
// Loads the field start address on field start, adds one per accepted word
// inside a row, and adds the modulo on the last word of a row.
// Assumes ADDR_W exceeds CNT_W.
module dwin_addr_step #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              word_adv,
    input  logic              row_adv,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [CNT_W-1:0]  modulo,
    output logic [ADDR_W-1:0] addr
);

    localparam int               PAD      = ADDR_W - CNT_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] mod_ext;

    // Widen the modulo to the address width
    always_comb mod_ext = {{PAD{1'b0}}, modulo};

    // Step the address by one word or by the row modulo
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (field_start) begin
            addr <= start_base;
        end else if (word_adv) begin
            addr <= addr + ADDR_ONE;
        end else if (row_adv) begin
            addr <= addr + mod_ext;
        end
    end

    // R4: leaving a row jumps by the captured modulo
    assert_row_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        row_adv && !field_start |=> addr == $past(addr) + $past(mod_ext));

endmodule

// File: rtl/dwin_fetch_addr.sv
// Display window fetch address generator, top level.
// Joins the setup capture, the row/word sequencer and the address register
// behind a request/acknowledge read port. Assumes field_start and line_start
// are one-cycle pulses from the display timing generator.
module dwin_fetch_addr
    import dwin_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         field_start,
    input  logic                         line_start,
    input  logic                         interlace_en,
    input  logic [ADDR_W-1:0]            long_base,
    input  logic [ADDR_W-1:0]            short_base,
    input  logic [SIZE_FIELDS*CNT_W-1:0] size_cfg,
    input  logic                         rd_ack,
    output logic                         rd_req,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic                         field_short
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0]  width_m1;
    logic [CNT_W-1:0]  rows_m1;
    logic [CNT_W-1:0]  modulo;
    logic [ADDR_W-1:0] start_base;
    logic              word_adv;
    logic              row_adv;

    dwin_cfg_latch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start  (field_start),
        .interlace_en (interlace_en),
        .long_base    (long_base),
        .short_base   (short_base),
        .size_word    (size_cfg),
        .width_m1     (width_m1),
        .rows_m1      (rows_m1),
        .modulo       (modulo),
        .start_base   (start_base),
        .field_short  (field_short)
    );

    dwin_scan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_start  (line_start),
        .rd_ack      (rd_ack),
        .width_m1    (width_m1),
        .rows_m1     (rows_m1),
        .rd_req      (rd_req),
        .word_adv    (word_adv),
        .row_adv     (row_adv)
    );

    dwin_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .word_adv    (word_adv),
        .row_adv     (row_adv),
        .start_base  (start_base),
        .modulo      (modulo),
        .addr        (rd_addr)
    );

    // R7: a stalled request keeps its address
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack && !field_start |=> rd_req && $stable(rd_addr));

    // R3: an accepted word is followed by the next word or by the end of the row
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && !field_start |=> !rd_req || rd_addr == $past(rd_addr) + ADDR_ONE);

endmodule

// File: tb/tb_dwin_fetch_addr.sv
module tb_dwin_fetch_addr;
    localparam int AW = 24;
    localparam int CW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            field_start = 1'b0;
    logic            line_start = 1'b0;
    logic            interlace_en = 1'b0;
    logic [AW-1:0]   long_base = '0;
    logic [AW-1:0]   short_base = '0;
    logic [3*CW-1:0] size_cfg = '0;
    logic            rd_ack = 1'b0;
    logic            rd_req;
    logic [AW-1:0]   rd_addr;
    logic            field_short;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit next_short_m = 1'b0;
    bit record = 1'b0;
    int hits [160];

    always #10 clk = ~clk;

    dwin_fetch_addr #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
        .interlace_en(interlace_en), .long_base(long_base), .short_base(short_base),
        .size_cfg(size_cfg), .rd_ack(rd_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .field_short(field_short)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int line_words(input int xres, input int bpp);
        return (((xres * bpp) + 31) & ~31) >> 5;
    endfunction

    // Start a field; the bench model of R6 picks the expected field
    task automatic start_field(input bit intl, input int lb, input int sb, input int wf,
                               input int rows, input int md, output bit exp_short);
        interlace_en = intl;
        long_base    = AW'(lb);
        short_base   = AW'(sb);
        size_cfg     = {CW'(md), CW'(rows), CW'(wf)};   // R2 packing
        rd_ack       = 1'b0;
        line_start   = 1'b0;
        field_start  = 1'b1;
        exp_short    = intl && next_short_m;
        next_short_m = intl && !next_short_m;
        @(negedge clk);
        field_start = 1'b0;
        chk(field_short == exp_short, "R6 field select", longint'(field_short), longint'(exp_short));
        chk(rd_req == 1'b0, "R9 no request after field start", longint'(rd_req), 0);
    endtask

    // Scan all rows and check every offered address (R3, R4, R7)
    task automatic scan_rows(input int base, input int wf, input int rows, input int md,
                             input bit disturb, input bit inject_ls, input int seed);
        for (int r = 0; r <= rows; r++) begin
            if (disturb && r == 1) begin
                size_cfg     = ~size_cfg;       // R8: ignored until next field
                long_base    = long_base + AW'(24'h777);
                short_base   = short_base + AW'(24'h333);
                interlace_en = ~interlace_en;
            end
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            begin
                int w = 0;
                int guard = 0;
                while (w <= wf && guard < 64) begin
                    int exp;
                    exp = base + r * (wf + md) + w;
                    chk(rd_req == 1'b1 && rd_addr == AW'(exp), "R3 R4 R7 R8 word address",
                        longint'(rd_addr), longint'(exp));
                    rd_ack     = ((guard + seed) % 3) != 0;
                    line_start = inject_ls && guard == 1;   // R5: ignored mid-row
                    if (rd_ack) begin
                        if (record) begin
                            int idx;
                            idx = int'(rd_addr) - 'h1000;
                            if (idx >= 0 && idx < 160) hits[idx]++;
                            else chk(1'b0, "R10 address in frame", longint'(rd_addr), 'h1000);
                        end
                        w++;
                    end
                    guard++;
                    @(negedge clk);
                end
                if (guard >= 64) chk(1'b0, "R3 row did not finish", longint'(w), longint'(wf + 1));
            end
            rd_ack     = 1'b0;
            line_start = 1'b0;
            chk(rd_req == 1'b0, "R3 row length ends request", longint'(rd_req), 0);
        end
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        @(negedge clk);
        chk(rd_req == 1'b0, "R5 no row after last row", longint'(rd_req), 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit es;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_req == 1'b0, "R1 reset request", longint'(rd_req), 0);
        chk(field_short == 1'b0, "R1 reset field flag", longint'(field_short), 0);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        @(negedge clk);
        chk(rd_req == 1'b0, "R1 line start before field", longint'(rd_req), 0);

        // Sweep of scan modes and small geometries (R2 R3 R4 R6)
        for (int il = 0; il < 2; il++)
            for (int wf = 0; wf < 4; wf++)
                for (int rw = 0; rw < 4; rw++)
                    for (int md = 1; md < 4; md++) begin
                        int lb;
                        int sb;
                        lb = 'h100 + wf * 'h40 + rw * 'h10;
                        sb = lb + 'h800;
                        start_field(il[0], lb, sb, wf, rw, md, es);
                        scan_rows(es ? sb : lb, wf, rw, md, 1'b0, 1'b0, wf + rw + md);
                    end

        // R8 setup changes mid-field, R5 line start mid-row
        start_field(1'b0, 'h2000, 'h3000, 2, 2, 2, es);
        scan_rows('h2000, 2, 2, 2, 1'b1, 1'b1, 1);

        // R9 field start in the middle of a row
        start_field(1'b0, 'h4000, 'h5000, 5, 1, 1, es);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        chk(rd_req == 1'b1 && rd_addr == AW'('h4001), "R9 row under way", longint'(rd_addr), 'h4001);
        start_field(1'b0, 'h6000, 'h7000, 1, 1, 3, es);
        scan_rows('h6000, 1, 1, 3, 1'b0, 1'b0, 2);

        // R10 interlaced pair covers a 40x8, 16 bpp frame exactly once
        begin
            int lw;
            lw = line_words(40, 16);
            chk(lw == 20, "R10 line length", longint'(lw), 20);
            for (int i = 0; i < 160; i++) hits[i] = 0;
            start_field(1'b0, 'h1000, 'h1000, 0, 0, 1, es);   // progressive field resets parity
            scan_rows('h1000, 0, 0, 1, 1'b0, 1'b0, 0);
            record = 1'b1;
            for (int f = 0; f < 2; f++) begin
                start_field(1'b1, 'h1000, 'h1000 + lw, lw - 1, 8 / 2 - 1, 1 + lw, es);
                chk(es == bit'(f), "R6 interlace order", longint'(es), longint'(f));
                scan_rows(es ? 'h1000 + lw : 'h1000, lw - 1, 3, 1 + lw, 1'b0, 1'b0, f);
            end
            record = 1'b0;
            for (int i = 0; i < 160; i++)
                if (hits[i] != 1) chk(1'b0, "R10 word read once", longint'(hits[i]), 1);
            chk(1'b1, "R10 coverage pass", 0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule